// File: doc/BRIEF.md
# UART FIFO Level Events and Flow Control

This block sits beside the 64-deep receive and transmit FIFOs of a serial port. It does not store characters and does not shape bits on the line. It compares the two occupancy counts against thresholds that coded fields of one control word select. From those comparisons it raises four events for the interrupt logic: receive level reached, receive idle timeout, transmit space available, and receive overrun. It also drives the request-to-send pin from the receive occupancy and gates the start of each transmit character with the clear-to-send pin.

The receive FIFO's write strobe passes through this block. A character that arrives when the FIFO is full is therefore discarded here and reported as an overrun. The idle timeout counts character-time ticks supplied by the baud logic. The transmitter asks for permission before loading each new character. A character already on the line is never cut short, because only the load is gated.

Top module: `uart_level_flow`

## Requirements
- R1: `rx_trig` is high one cycle after `rx_count` is at or above the level coded in control bits 4:2. The codes 0,1,2,3,4,5 give 1,4,8,16,32,48 characters, and codes 6 and 7 also give 48.
- R2: `tx_req` is high one cycle after `tx_count` is at or below the threshold coded in control bits 1:0. The codes 0,1,2,3 give 0 (empty), 4, 8 and 16 characters.
- R3: Control bits 17:16 select the idle timeout. Code 0 disables it, and codes 1,2,3 give 4, 8 and 16 `char_tick` pulses. `rx_tmo` rises after that many ticks while the receive FIFO is non-empty and nothing is pushed or popped. It stays low while the FIFO is empty, and an empty FIFO holds the count at zero.
- R4: Any `rx_push` or `rx_pop` returns the tick count to zero. `rx_tmo` falls in the next cycle, and a full new interval of ticks is needed before it rises again.
- R5: `rx_wr_en` passes `rx_push` while `rx_count` is below 64. A push when `rx_count` equals 64 is dropped (`rx_wr_en` low), and `rx_ovr` is high for exactly the following cycle.
- R6: When control bit 18 is set, request-to-send is asserted while `rx_count` is below the watermark coded in bits 20:19, and deasserted at or above it. The codes 0,1,2,3 give 8,16,32,48 characters. When bit 18 is clear, request-to-send stays asserted. The pin follows one cycle after the count.
- R7: An asserted request-to-send drives `rts_pin` high. Control bit 21 inverts the pin.
- R8: When control bit 14 is set, `tx_load_gnt` follows `tx_load_req` only while clear-to-send is asserted, and is low otherwise. Clear-to-send is asserted when `cts_pin`, after two synchronizing flops, is high, or low when control bit 15 is set. When bit 14 is clear, `tx_load_gnt` equals `tx_load_req`.
- R9: In reset, `rx_trig`, `tx_req`, `rx_tmo` and `rx_ovr` are low, and request-to-send is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_word | input | 32 | Control word holding the coded fields |
| rx_count | input | 7 | Receive FIFO occupancy |
| tx_count | input | 7 | Transmit FIFO occupancy |
| rx_push | input | 1 | Received character ready to be written |
| rx_pop | input | 1 | Receive FIFO read strobe |
| char_tick | input | 1 | One pulse per character time |
| tx_load_req | input | 1 | Transmitter wants to start the next character |
| cts_pin | input | 1 | Clear-to-send pin, asynchronous |
| rx_wr_en | output | 1 | Receive FIFO write enable |
| rx_trig | output | 1 | Receive level reached |
| rx_tmo | output | 1 | Receive idle timeout |
| rx_ovr | output | 1 | One-cycle overrun pulse |
| tx_req | output | 1 | Transmit space available |
| tx_load_gnt | output | 1 | Permission to load the next character |
| rts_pin | output | 1 | Request-to-send pin |

## Verification
On every cycle, the assertions check the following. The overrun pulse is tied to a dropped push in the cycle before. The idle count never exceeds sixteen and returns to zero after any FIFO traffic. A receive trigger or a dropped request-to-send only follows a non-empty FIFO, and a transmit request only follows a count within the largest threshold. Only the bench scenarios can show the exact level decoded from each field code, the tick count at which the timeout fires for each code, the two-cycle latency of clear-to-send, and the pin inversions.

// File: rtl/uart_lvl_pkg.sv
// Package: field positions of the control word and decoders from field codes
// to character counts. Assumes FIFOs of at least 48 entries.
package uart_lvl_pkg;

    localparam int CTRL_W      = 32;
    localparam int TXTHR_LSB   = 0;
    localparam int RXTRIG_LSB  = 2;
    localparam int CTS_EN_BIT  = 14;
    localparam int CTS_INV_BIT = 15;
    localparam int TMO_LSB     = 16;
    localparam int RTS_EN_BIT  = 18;
    localparam int RTS_WM_LSB  = 19;
    localparam int RTS_INV_BIT = 21;

    typedef struct packed {
        logic [2:0] rx_trig;
        logic [1:0] tx_thr;
        logic [1:0] tmo;
        logic       cts_en;
        logic       cts_inv;
        logic       rts_en;
        logic [1:0] rts_wm;
        logic       rts_inv;
    } lvl_cfg_t;

    // Receive trigger level; the two spare codes saturate at the top level.
    function automatic logic [7:0] rx_trig_level(input logic [2:0] code);
        case (code)
            3'd0:    return 8'd1;
            3'd1:    return 8'd4;
            3'd2:    return 8'd8;
            3'd3:    return 8'd16;
            3'd4:    return 8'd32;
            default: return 8'd48;
        endcase
    endfunction

    // Transmit low-water threshold.
    function automatic logic [7:0] tx_thr_level(input logic [1:0] code);
        case (code)
            2'd0:    return 8'd0;
            2'd1:    return 8'd4;
            2'd2:    return 8'd8;
            default: return 8'd16;
        endcase
    endfunction

    // Idle timeout in character ticks; zero means disabled.
    function automatic logic [4:0] tmo_ticks(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd0;
            2'd1:    return 5'd4;
            2'd2:    return 5'd8;
            default: return 5'd16;
        endcase
    endfunction

    // Request-to-send deassert watermark.
    function automatic logic [7:0] rts_mark(input logic [1:0] code);
        case (code)
            2'd0:    return 8'd8;
            2'd1:    return 8'd16;
            2'd2:    return 8'd32;
            default: return 8'd48;
        endcase
    endfunction

    // Extract all fields from the control word.
    function automatic lvl_cfg_t decode_cfg(input logic [CTRL_W-1:0] w);
        lvl_cfg_t c;
        c.rx_trig = w[RXTRIG_LSB +: 3];
        c.tx_thr  = w[TXTHR_LSB +: 2];
        c.tmo     = w[TMO_LSB +: 2];
        c.cts_en  = w[CTS_EN_BIT];
        c.cts_inv = w[CTS_INV_BIT];
        c.rts_en  = w[RTS_EN_BIT];
        c.rts_wm  = w[RTS_WM_LSB +: 2];
        c.rts_inv = w[RTS_INV_BIT];
        return c;
    endfunction

endpackage

// File: rtl/uart_rx_watch.sv
// Receive-side level logic: write gating with overrun detection, the
// trigger-level event and the request-to-send watermark.
// Assumes rx_count is the FIFO occupancy for the current cycle.
module uart_rx_watch #(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_push,
    input  logic [2:0]       trig_code,
    input  logic             rts_en,
    input  logic [1:0]       rts_wm,
    output logic             rx_wr_en,
    output logic             rx_trig,
    output logic             rx_ovr,
    output logic             rts_act
);
    localparam int CMP_W = (CNT_W > 8) ? CNT_W : 8;

    logic [7:0]       trig_lvl;
    logic [7:0]       wm_lvl;
    logic [CMP_W-1:0] cnt_x;
    logic             full;

    assign trig_lvl = uart_lvl_pkg::rx_trig_level(trig_code);
    assign wm_lvl   = uart_lvl_pkg::rts_mark(rts_wm);
    assign cnt_x    = CMP_W'(rx_count);
    assign full     = (cnt_x >= CMP_W'(DEPTH));
    assign rx_wr_en = rx_push & ~full;

    // Register the trigger, overrun and request-to-send state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_trig <= 1'b0;
            rx_ovr  <= 1'b0;
            rts_act <= 1'b1;
        end else begin
            rx_trig <= (cnt_x >= CMP_W'(trig_lvl));
            rx_ovr  <= rx_push & full;
            rts_act <= ~rts_en | (cnt_x < CMP_W'(wm_lvl));
        end
    end

    // R5: a push into a full FIFO is reported in the next cycle
    a_r5_ovr_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_count == CNT_W'(DEPTH)) |=> rx_ovr);
    // R5: no overrun pulse without a dropped push before it
    a_r5_ovr_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovr |-> $past(rx_push && !rx_wr_en));
    // R1: the lowest trigger level is one character
    a_r1_trig_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        rx_trig |-> $past(rx_count != '0));
    // R6: request-to-send only drops after the FIFO held data
    a_r6_rts_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        !rts_act |-> $past(rx_count != '0));

endmodule

// File: rtl/uart_rx_timeout.sv
// Receive idle timeout: counts character ticks while the receive FIFO holds
// data and sees no traffic. Assumes char_tick is a one-cycle pulse.
module uart_rx_timeout #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             char_tick,
    input  logic [1:0]       tmo_code,
    output logic             rx_tmo
);
    logic [4:0] limit;
    logic [4:0] idle_cnt;
    logic       empty;

    assign limit = uart_lvl_pkg::tmo_ticks(tmo_code);
    assign empty = (rx_count == '0);

    // Count idle ticks up to the limit; clear on traffic or empty FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
        end else if (empty || rx_push || rx_pop) begin
            idle_cnt <= '0;
        end else if (char_tick && idle_cnt < limit) begin
            idle_cnt <= idle_cnt + 5'd1;
        end
    end

    assign rx_tmo = (limit != '0) && !empty && (idle_cnt >= limit);

    // R4: traffic restarts the interval
    a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push || rx_pop) |=> (idle_cnt == 5'd0));
    // R3: the counter never passes the longest interval
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cnt <= 5'd16);

endmodule

// File: rtl/uart_tx_watch.sv
// Transmit-side logic: the low-water request and the clear-to-send gate on
// character loads. Assumes cts_pin is asynchronous to clk.
module uart_tx_watch #(
    parameter int CNT_W       = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [1:0]       thr_code,
    input  logic             cts_pin,
    input  logic             cts_en,
    input  logic             cts_inv,
    input  logic             tx_load_req,
    output logic             tx_req,
    output logic             tx_load_gnt
);
    localparam int CMP_W = (CNT_W > 8) ? CNT_W : 8;

    logic [7:0] thr_lvl;
    logic       cts_s;
    logic       cts_ok;

    assign thr_lvl = uart_lvl_pkg::tx_thr_level(thr_code);

    generate
        if (SYNC_STAGES == 0) begin : g_nosync
            assign cts_s = cts_pin;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] sync_q;
            // Synchronize the clear-to-send pin.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sync_q <= '0;
                end else begin
                    sync_q[0] <= cts_pin;
                    for (int i = 1; i < SYNC_STAGES; i++) begin
                        sync_q[i] <= sync_q[i-1];
                    end
                end
            end
            assign cts_s = sync_q[SYNC_STAGES-1];
        end
    endgenerate

    assign cts_ok      = cts_s ^ cts_inv;
    assign tx_load_gnt = tx_load_req & (~cts_en | cts_ok);

    // Register the transmit low-water request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_req <= 1'b0;
        end else begin
            tx_req <= (CMP_W'(tx_count) <= CMP_W'(thr_lvl));
        end
    end

    // R2: a request only follows a count within the largest threshold
    a_r2_req_low: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> $past(CMP_W'(tx_count) <= CMP_W'(16)));

endmodule

// File: rtl/uart_level_flow.sv
// Top: decodes the control word and connects the receive watch, the idle
// timeout and the transmit watch. Assumes both FIFOs have DEPTH entries.
module uart_level_flow #(
    parameter int DEPTH       = 64,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = $clog2(DEPTH + 1)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [uart_lvl_pkg::CTRL_W-1:0] ctrl_word,
    input  logic [CNT_W-1:0]                rx_count,
    input  logic [CNT_W-1:0]                tx_count,
    input  logic                            rx_push,
    input  logic                            rx_pop,
    input  logic                            char_tick,
    input  logic                            tx_load_req,
    input  logic                            cts_pin,
    output logic                            rx_wr_en,
    output logic                            rx_trig,
    output logic                            rx_tmo,
    output logic                            rx_ovr,
    output logic                            tx_req,
    output logic                            tx_load_gnt,
    output logic                            rts_pin
);
    uart_lvl_pkg::lvl_cfg_t cfg;
    logic rts_act;
    logic unused_ctrl_bits;

    assign cfg              = uart_lvl_pkg::decode_cfg(ctrl_word);
    assign unused_ctrl_bits = ^{ctrl_word[31:22], ctrl_word[13:5]};

    uart_rx_watch #(.DEPTH(DEPTH), .CNT_W(CNT_W)) rx_watch_i (
        .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .rx_push(rx_push),
        .trig_code(cfg.rx_trig), .rts_en(cfg.rts_en), .rts_wm(cfg.rts_wm),
        .rx_wr_en(rx_wr_en), .rx_trig(rx_trig), .rx_ovr(rx_ovr),
        .rts_act(rts_act)
    );

    uart_rx_timeout #(.CNT_W(CNT_W)) rx_tmo_i (
        .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .rx_push(rx_push),
        .rx_pop(rx_pop), .char_tick(char_tick), .tmo_code(cfg.tmo),
        .rx_tmo(rx_tmo)
    );

    uart_tx_watch #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) tx_watch_i (
        .clk(clk), .rst_n(rst_n), .tx_count(tx_count), .thr_code(cfg.tx_thr),
        .cts_pin(cts_pin), .cts_en(cfg.cts_en), .cts_inv(cfg.cts_inv),
        .tx_load_req(tx_load_req), .tx_req(tx_req), .tx_load_gnt(tx_load_gnt)
    );

    assign rts_pin = rts_act ^ cfg.rts_inv;

endmodule

// File: tb/uart_level_flow_tb.sv
module uart_level_flow_tb_top;

    typedef struct packed {
        logic [31:0] ctrl;
        logic [6:0]  rxc;
        logic [6:0]  txc;
        logic        trig;
        logic        txr;
        logic        rts;
    } vec_t;

    // ctrl, rx_count, tx_count, expected rx_trig, tx_req, rts_pin
    localparam vec_t VEC [0:14] = '{
        '{32'h0000_0000, 7'd0,  7'd0,  1'b0, 1'b1, 1'b1},
        '{32'h0000_0000, 7'd1,  7'd1,  1'b1, 1'b0, 1'b1},
        '{32'h0000_0005, 7'd3,  7'd4,  1'b0, 1'b1, 1'b1},
        '{32'h0000_0005, 7'd4,  7'd5,  1'b1, 1'b0, 1'b1},
        '{32'h0000_0012, 7'd31, 7'd8,  1'b0, 1'b1, 1'b1},
        '{32'h0000_0017, 7'd48, 7'd17, 1'b1, 1'b0, 1'b1},
        '{32'h0000_001F, 7'd47, 7'd16, 1'b0, 1'b1, 1'b1},
        '{32'h0000_000F, 7'd64, 7'd64, 1'b1, 1'b0, 1'b1},
        '{32'h0004_0000, 7'd7,  7'd0,  1'b1, 1'b1, 1'b1},
        '{32'h0004_0000, 7'd8,  7'd0,  1'b1, 1'b1, 1'b0},
        '{32'h001C_0000, 7'd47, 7'd0,  1'b1, 1'b1, 1'b1},
        '{32'h001C_0000, 7'd48, 7'd0,  1'b1, 1'b1, 1'b0},
        '{32'h0034_0000, 7'd20, 7'd0,  1'b1, 1'b1, 1'b0},
        '{32'h002C_0000, 7'd16, 7'd0,  1'b1, 1'b1, 1'b1},
        '{32'h0020_0000, 7'd64, 7'd0,  1'b1, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ctrl_word = '0;
    logic [6:0]  rx_count = '0;
    logic [6:0]  tx_count = '0;
    logic        rx_push = 1'b0;
    logic        rx_pop = 1'b0;
    logic        char_tick = 1'b0;
    logic        tx_load_req = 1'b0;
    logic        cts_pin = 1'b0;
    logic        rx_wr_en, rx_trig, rx_tmo, rx_ovr, tx_req, tx_load_gnt, rts_pin;

    int checks = 0;
    int errs = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    uart_level_flow dut_i (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .rx_count(rx_count),
        .tx_count(tx_count), .rx_push(rx_push), .rx_pop(rx_pop),
        .char_tick(char_tick), .tx_load_req(tx_load_req), .cts_pin(cts_pin),
        .rx_wr_en(rx_wr_en), .rx_trig(rx_trig), .rx_tmo(rx_tmo),
        .rx_ovr(rx_ovr), .tx_req(tx_req), .tx_load_gnt(tx_load_gnt),
        .rts_pin(rts_pin)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock edge, returning at the following falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            char_tick = 1'b1;
            step();
            char_tick = 1'b0;
            step();
        end
    endtask

    task automatic pulse_pop();
        rx_pop = 1'b1;
        step();
        rx_pop = 1'b0;
        step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL all: watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        @(negedge clk);
        step();
        chk("R9 rx_trig", rx_trig, 1'b0);
        chk("R9 tx_req", tx_req, 1'b0);
        chk("R9 rx_tmo", rx_tmo, 1'b0);
        chk("R9 rx_ovr", rx_ovr, 1'b0);
        chk("R9 rts_pin", rts_pin, 1'b1);
        rst_n = 1'b1;
        step();

        // R1, R2, R6, R7: level table
        for (int v = 0; v < 15; v++) begin
            ctrl_word = VEC[v].ctrl;
            rx_count  = VEC[v].rxc;
            tx_count  = VEC[v].txc;
            step();
            chk($sformatf("R1 vec%0d", v), rx_trig, VEC[v].trig);
            chk($sformatf("R2 vec%0d", v), tx_req, VEC[v].txr);
            chk($sformatf("R6/R7 vec%0d", v), rts_pin, VEC[v].rts);
        end

        // R3: four-tick timeout
        ctrl_word = 32'h0001_0000;
        rx_count = 7'd3;
        pulse_pop();
        tick(3);
        chk("R3 before 4 ticks", rx_tmo, 1'b0);
        tick(1);
        chk("R3 at 4 ticks", rx_tmo, 1'b1);
        // R4: push restarts the interval
        rx_push = 1'b1;
        step();
        rx_push = 1'b0;
        chk("R4 cleared by push", rx_tmo, 1'b0);
        tick(3);
        chk("R4 new interval not yet", rx_tmo, 1'b0);
        tick(1);
        chk("R4 new interval done", rx_tmo, 1'b1);
        pulse_pop();
        chk("R4 cleared by pop", rx_tmo, 1'b0);

        // R3: sixteen-tick code
        ctrl_word = 32'h0003_0000;
        tick(15);
        chk("R3 code3 at 15", rx_tmo, 1'b0);
        tick(1);
        chk("R3 code3 at 16", rx_tmo, 1'b1);

        // R3: disabled code
        ctrl_word = 32'h0000_0000;
        pulse_pop();
        tick(20);
        chk("R3 disabled", rx_tmo, 1'b0);

        // R3: empty FIFO holds the count at zero
        ctrl_word = 32'h0001_0000;
        rx_count = 7'd0;
        tick(6);
        chk("R3 empty", rx_tmo, 1'b0);
        rx_count = 7'd1;
        step();
        chk("R3 just non-empty", rx_tmo, 1'b0);
        tick(4);
        chk("R3 after refill", rx_tmo, 1'b1);

        // R5: overrun on a full FIFO
        ctrl_word = 32'h0;
        rx_count = 7'd64;
        rx_push = 1'b1;
        #1;
        chk("R5 write blocked", rx_wr_en, 1'b0);
        step();
        rx_push = 1'b0;
        chk("R5 overrun pulse", rx_ovr, 1'b1);
        step();
        chk("R5 pulse one cycle", rx_ovr, 1'b0);
        rx_count = 7'd63;
        rx_push = 1'b1;
        #1;
        chk("R5 write passes", rx_wr_en, 1'b1);
        step();
        rx_push = 1'b0;
        chk("R5 no overrun below full", rx_ovr, 1'b0);

        // R8: clear-to-send gating
        ctrl_word = 32'h0000_4000;
        tx_load_req = 1'b1;
        cts_pin = 1'b0;
        step(); step(); step();
        chk("R8 held off", tx_load_gnt, 1'b0);
        cts_pin = 1'b1;
        step();
        chk("R8 sync latency", tx_load_gnt, 1'b0);
        step();
        chk("R8 granted", tx_load_gnt, 1'b1);
        ctrl_word = 32'h0000_C000;
        step(); step();
        chk("R8 inverted high", tx_load_gnt, 1'b0);
        cts_pin = 1'b0;
        step(); step();
        chk("R8 inverted low", tx_load_gnt, 1'b1);
        ctrl_word = 32'h0000_8000;
        cts_pin = 1'b1;
        step(); step();
        chk("R8 disabled", tx_load_gnt, 1'b1);
        tx_load_req = 1'b0;
        #1;
        chk("R8 no request", tx_load_gnt, 1'b0);

        // R9: reset again with data present
        rst_n = 1'b0;
        rx_count = 7'd64;
        ctrl_word = 32'h0004_0000;
        step();
        chk("R9 rts in reset", rts_pin, 1'b1);
        chk("R9 trig in reset", rx_trig, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
        $finish;
    end

endmodule